// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block gathers general-purpose lines into banks of up to 32 lines each and turns line activity into interrupts. Every line can be programmed as an input or an output, and an output can be operated as open drain. Each input line is synchronized and then watched for a level, a single edge or any edge. The result is latched into a per-bank pending register that software clears by writing ones.

A line is active when its pending bit and its enable bit are both set. The active lines of all banks are OR-ed into one interrupt output, which can be quiesced with a gate input. A separate wake output follows the same active set but ignores that gate, so a sleeping system can still be woken while the normal interrupt is held off.

Software reaches eight 32-bit registers per bank through a word-addressed bus with a combinational read port. The global line number selects a bank with its upper bits and a bit inside the bank with its low five bits. Lines at or above the configured bank width do not exist: they read as zero and never raise an event.

Top module: `banked_gpio_irq`

## Requirements
- R1: The word address is {bank, index}, with the bank in the bits above bit 2 and the register index in bits 2:0. Index 0 is open-drain select, 1 is data, 2 is direction, 3 is polarity, 4 is any-edge, 5 is enable, 6 is level select and 7 is pending. After reset every register of every bank reads zero, and the irq and wake outputs are low.
- R2: Direction bit 1 makes the line an output. Reading the data register returns the output latch for output lines. For input lines it returns the input state, which appears on the second clock edge after the pin changes.
- R3: line_out carries the data latch. line_oe is high for an output line, unless its open-drain bit is set and its data latch is 1, in which case line_oe is low.
- R4: With any-edge=0 and level=1, the pending bit is set on every cycle in which the synchronized input equals the polarity bit: polarity 1 gives active-high and polarity 0 gives active-low.
- R5: With any-edge=0 and level=0, polarity 1 latches a rising edge and polarity 0 latches a falling edge. The opposite edge latches nothing.
- R6: With any-edge=1, a change in either direction latches the pending bit, whatever the level and polarity bits hold.
- R7: Writing a 1 to a pending bit clears it and writing a 0 leaves it as it was. A clear takes priority over an event in the same cycle. A level condition that is still present sets the bit again one cycle later.
- R8: Pending bits latch while their enable bit is 0. A set pending bit stays set until it is cleared.
- R9: irq_out is high when irq_enable is high and some bank has a line whose pending bit and enable bit are both 1.
- R10: wake_out is high when any bank has an active line, whatever the state of irq_enable.
- R11: Register bits at or above BANK_LINES read as zero, drive nothing and never set a pending bit.
- R12: An access whose bank field is NUM_BANKS or larger reads zero and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address {bank, register index} |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_enable | input | 1 | Gate for irq_out; has no effect on wake_out |
| line_in | input | NUM_BANKS*32 | Line inputs, 32 slots per bank |
| line_out | output | NUM_BANKS*32 | Output data per line |
| line_oe | output | NUM_BANKS*32 | Output enable per line |
| irq_out | output | 1 | Combined interrupt of all banks |
| wake_out | output | 1 | Wake request, not affected by irq_enable |

## Verification
The bench builds the block with NUM_BANKS=3 and BANK_LINES=20. Three banks make the bank field two bits wide, so bank value 3 is an address that exists on the bus but has no bank behind it. This exercises the out-of-range decode, and a third bank shows that any bank alone can raise the shared interrupt. A width of 20 leaves twelve nonexistent lines in every bank, so the read masking and the suppression of events on those lines can be driven from the pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [2:0] IDX_OPEN_DRAIN = 3'd0;
  localparam logic [2:0] IDX_DATA       = 3'd1;
  localparam logic [2:0] IDX_DIR        = 3'd2;
  localparam logic [2:0] IDX_POLARITY   = 3'd3;
  localparam logic [2:0] IDX_ANY_EDGE   = 3'd4;
  localparam logic [2:0] IDX_ENABLE     = 3'd5;
  localparam logic [2:0] IDX_LEVEL      = 3'd6;
  localparam logic [2:0] IDX_PENDING    = 3'd7;

  // Per-line trigger decision from the three mode bits.
  function automatic logic [31:0] line_event(
    input logic [31:0] lvl, input logic [31:0] pol, input logic [31:0] any,
    input logic [31:0] cur, input logic [31:0] prv);
    logic [31:0] rise, fall, lvl_hit, edge_hit;
    rise     = cur & ~prv;
    fall     = ~cur & prv;
    lvl_hit  = ~(cur ^ pol);
    edge_hit = (pol & rise) | (~pol & fall);
    return (any & (rise | fall)) | (~any & lvl & lvl_hit) | (~any & ~lvl & edge_hit);
  endfunction

  function automatic logic [31:0] pad_enable(
    input logic [31:0] dir, input logic [31:0] od, input logic [31:0] dout);
    return dir & (~od | ~dout);
  endfunction

  function automatic logic [31:0] data_view(
    input logic [31:0] dir, input logic [31:0] dout, input logic [31:0] pins);
    return (dir & dout) | (~dir & pins);
  endfunction

endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      cur    <= '0;
      prv    <= '0;
    end else begin
      stage1 <= d_in;
      cur    <= stage1;
      prv    <= cur;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  sel,
  input  logic [31:0] wdata,
  input  logic [31:0] cur,
  input  logic [31:0] prv,
  output logic [31:0] rdata,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe,
  output logic [31:0] pending,
  output logic [31:0] enable,
  output logic [31:0] clr,
  output logic [31:0] evt
);
  localparam logic [63:0] ONE64 = 64'd1;
  localparam logic [31:0] VALID = 32'((ONE64 << LINES) - ONE64);

  logic [31:0] cfg_q [7];
  logic [31:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) cfg_q[i] <= '0;
    end else if (wr_en && sel != IDX_PENDING) begin
      cfg_q[sel] <= wdata & VALID;
    end
  end

  assign clr = (wr_en && sel == IDX_PENDING) ? (wdata & VALID) : '0;
  assign evt = line_event(cfg_q[IDX_LEVEL], cfg_q[IDX_POLARITY], cfg_q[IDX_ANY_EDGE],
                          cur, prv) & VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | evt) & ~clr;
  end

  always_comb begin
    if (sel == IDX_DATA)
      rdata = data_view(cfg_q[IDX_DIR], cfg_q[IDX_DATA], cur) & VALID;
    else if (sel == IDX_PENDING)
      rdata = pend_q;
    else
      rdata = cfg_q[sel];
  end

  assign pad_out = cfg_q[IDX_DATA];
  assign pad_oe  = pad_enable(cfg_q[IDX_DIR], cfg_q[IDX_OPEN_DRAIN], cfg_q[IDX_DATA]);
  assign pending = pend_q;
  assign enable  = cfg_q[IDX_ENABLE];
endmodule

// File: rtl/banked_gpio_irq.sv
module banked_gpio_irq #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_LINES = 32,
  localparam int TOTAL   = NUM_BANKS * 32,
  localparam int BANK_AW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W  = BANK_AW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_enable,
  input  logic [TOTAL-1:0]  line_in,
  output logic [TOTAL-1:0]  line_out,
  output logic [TOTAL-1:0]  line_oe,
  output logic              irq_out,
  output logic              wake_out
);
  logic [BANK_AW-1:0] bank_idx;
  logic               in_range;
  logic [TOTAL-1:0]   sync_cur, sync_prv;
  logic [31:0]        bank_rd [NUM_BANKS];

  // Named internal events for the checker.
  logic [NUM_BANKS-1:0][31:0] pend_all, enable_all, clr_all, evt_all;
  logic                       any_active;

  assign bank_idx = bus_addr[ADDR_W-1:3];
  assign in_range = (int'(bank_idx) < NUM_BANKS);

  gpio_line_sync #(.W(TOTAL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(line_in), .cur(sync_cur), .prv(sync_prv)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_b;
    assign wr_b = bus_we && in_range && (bank_idx == BANK_AW'(b));
    gpio_bank #(.LINES(BANK_LINES)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .sel(bus_addr[2:0]), .wdata(bus_wdata),
      .cur(sync_cur[b*32 +: 32]), .prv(sync_prv[b*32 +: 32]),
      .rdata(bank_rd[b]), .pad_out(line_out[b*32 +: 32]), .pad_oe(line_oe[b*32 +: 32]),
      .pending(pend_all[b]), .enable(enable_all[b]), .clr(clr_all[b]), .evt(evt_all[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (in_range && bank_idx == BANK_AW'(b)) bus_rdata = bank_rd[b];
  end

  assign any_active = |(pend_all & enable_all);
  assign irq_out    = irq_enable & any_active;
  assign wake_out   = any_active;
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_LINES = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       irq_enable,
  input logic                       irq_out,
  input logic                       wake_out,
  input logic [NUM_BANKS-1:0][31:0] pend_all,
  input logic [NUM_BANKS-1:0][31:0] enable_all,
  input logic [NUM_BANKS-1:0][31:0] clr_all
);
  localparam logic [63:0] ONE64 = 64'd1;
  localparam logic [31:0] VALID = 32'((ONE64 << BANK_LINES) - ONE64);
  localparam logic [NUM_BANKS*32-1:0] VALID_ALL = {NUM_BANKS{VALID}};

  logic [NUM_BANKS*32-1:0] act_flat;
  assign act_flat = pend_all & enable_all;

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> !irq_out);

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (act_flat != '0));

  assert_wake_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_flat != '0) |-> wake_out);

  assert_wake_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |-> (act_flat != '0));

  assert_unused_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all & ~VALID_ALL) == '0);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all != '0) |=> ((pend_all & $past(clr_all)) == '0));

  assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_all) & ~$past(clr_all)) & ~pend_all) == '0);
endmodule

bind banked_gpio_irq gpio_irq_checker #(.NUM_BANKS(NUM_BANKS), .BANK_LINES(BANK_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_enable(irq_enable), .irq_out(irq_out),
  .wake_out(wake_out), .pend_all(pend_all), .enable_all(enable_all), .clr_all(clr_all)
);

// File: tb/banked_gpio_irq_test.sv
module banked_gpio_irq_test;
  localparam int NB = 3;
  localparam int BL = 20;
  localparam int TOT = NB * 32;
  localparam logic [31:0] VMASK = 32'h000F_FFFF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_enable = 1'b1;
  logic [TOT-1:0]  line_in = '0;
  logic [TOT-1:0]  line_out, line_oe;
  logic            irq_out, wake_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  banked_gpio_irq #(.NUM_BANKS(NB), .BANK_LINES(BL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_enable(irq_enable), .line_in(line_in),
    .line_out(line_out), .line_oe(line_oe), .irq_out(irq_out), .wake_out(wake_out)
  );

  // {level, polarity, any_edge, v0, v1, pending after v0 + clear, pending after v1}
  localparam logic [6:0] VEC [10] = '{
    7'b0100101, 7'b0101000, 7'b0001001, 7'b0000100, 7'b0010101,
    7'b0111001, 7'b1100101, 7'b1101011, 7'b1001001, 7'b1000111
  };

  function automatic logic [4:0] ad(input int bank, input int idx);
    return 5'(bank * 8 + idx);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1: reset state
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 8; r++) begin
        rd(ad(b, r), v);
        chk("R1 reset reg", v, 32'h0);
      end
    chk("R1 reset irq", {31'd0, irq_out}, 32'd0);
    chk("R1 reset wake", {31'd0, wake_out}, 32'd0);

    // R1/R11: register order and unused bits, on bank 2
    wr(ad(2, 0), 32'hFFFF_FFFF);
    wr(ad(2, 2), 32'hFFFF_FFFF);
    wr(ad(2, 1), 32'h000A_BCDE);
    wr(ad(2, 3), 32'h000F_0F0F);
    wr(ad(2, 4), 32'h0005_A5A5);
    wr(ad(2, 5), 32'h0003_3333);
    wr(ad(2, 6), 32'h0000_0000);
    rd(ad(2, 0), v); chk("R11 open-drain upper bits", v, VMASK);
    rd(ad(2, 1), v); chk("R1 data index", v, 32'h000A_BCDE);
    rd(ad(2, 2), v); chk("R1 direction index", v, VMASK);
    rd(ad(2, 3), v); chk("R1 polarity index", v, 32'h000F_0F0F);
    rd(ad(2, 4), v); chk("R1 any-edge index", v, 32'h0005_A5A5);
    rd(ad(2, 5), v); chk("R1 enable index", v, 32'h0003_3333);

    // R3: pad drive with open drain on, then off
    chk("R3 open-drain oe", line_oe[64 +: 32], 32'h0005_4321);
    chk("R3 line_out", line_out[64 +: 32], 32'h000A_BCDE);
    wr(ad(2, 0), 32'h0);
    chk("R3 push-pull oe", line_oe[64 +: 32], VMASK);
    for (int r = 0; r < 7; r++) wr(ad(2, r), 32'h0);

    // R2: input sampling latency and mixed directions on bank 0
    @(negedge clk);
    line_in[7:0] = 8'hA5;
    cyc(1); rd(ad(0, 1), v); chk("R2 one edge later", v, 32'h0);
    cyc(1); rd(ad(0, 1), v); chk("R2 two edges later", v, 32'h0000_00A5);
    wr(ad(0, 2), 32'h0000_000F);
    wr(ad(0, 1), 32'h0000_003C);
    rd(ad(0, 1), v); chk("R2 mixed directions", v, 32'h0000_00AC);
    wr(ad(0, 2), 32'h0);

    // R4/R5/R6: trigger modes on global line 37 (bank 1, bit 5)
    for (int i = 0; i < 10; i++) begin
      logic [6:0] e;
      string tag;
      e = VEC[i];
      tag = e[4] ? "R6 vector" : (e[6] ? "R4 vector" : "R5 vector");
      @(negedge clk); line_in[37] = e[3];
      cyc(5);
      wr(ad(1, 3), e[5] ? 32'h20 : 32'h0);
      wr(ad(1, 4), e[4] ? 32'h20 : 32'h0);
      wr(ad(1, 6), e[6] ? 32'h20 : 32'h0);
      wr(ad(1, 7), 32'hFFFF_FFFF);
      cyc(3);
      rd(ad(1, 7), v); chk(tag, v & 32'h20, e[1] ? 32'h20 : 32'h0);
      @(negedge clk); line_in[37] = e[2];
      cyc(5);
      rd(ad(1, 7), v); chk(tag, v & 32'h20, e[0] ? 32'h20 : 32'h0);
    end
    for (int r = 3; r < 7; r++) wr(ad(1, r), 32'h0);
    wr(ad(1, 7), 32'hFFFF_FFFF);

    // R11: nonexistent line 25 of bank 0 never latches or reads
    wr(ad(0, 4), 32'hFFFF_FFFF);
    wr(ad(0, 7), 32'hFFFF_FFFF);
    @(negedge clk); line_in[25] = 1'b1;
    cyc(5);
    rd(ad(0, 7), v); chk("R11 no pending on line 25", v, 32'h0);
    rd(ad(0, 1), v); chk("R11 data reads zero above width", v, 32'h0000_00A5);

    // R6 rise on line 1, fall on line 2, then R7 partial clear
    @(negedge clk); line_in[1] = 1'b1; line_in[2] = 1'b0;
    cyc(5);
    rd(ad(0, 7), v); chk("R6 both directions", v, 32'h0000_0006);
    wr(ad(0, 7), 32'h0000_0002);
    rd(ad(0, 7), v); chk("R7 write one clears", v, 32'h0000_0004);
    wr(ad(0, 7), 32'h0);
    rd(ad(0, 7), v); chk("R7 write zero keeps", v, 32'h0000_0004);

    // R7: level-high line 0 (input high) comes back one cycle after clear
    wr(ad(0, 4), 32'hFFFF_FFFE);
    wr(ad(0, 3), 32'h0000_0001);
    wr(ad(0, 6), 32'h0000_0001);
    cyc(1);
    wr(ad(0, 7), 32'h0000_0001);
    rd(ad(0, 7), v); chk("R7 cleared this cycle", v & 32'h1, 32'h0);
    cyc(1);
    rd(ad(0, 7), v); chk("R7 level sets again", v & 32'h1, 32'h1);

    // R8/R9/R10: masking, gating and wake
    rd(ad(0, 7), v); chk("R8 latched while masked", v, 32'h0000_0005);
    chk("R8 masked irq", {31'd0, irq_out}, 32'd0);
    chk("R8 masked wake", {31'd0, wake_out}, 32'd0);
    wr(ad(0, 5), 32'h0000_0004);
    chk("R9 irq on enabled pending", {31'd0, irq_out}, 32'd1);
    @(negedge clk); irq_enable = 1'b0; #1;
    chk("R9 irq gated", {31'd0, irq_out}, 32'd0);
    chk("R10 wake while gated", {31'd0, wake_out}, 32'd1);
    @(negedge clk); irq_enable = 1'b1;
    wr(ad(0, 7), 32'h0000_0004);
    chk("R9 irq drops after clear", {31'd0, irq_out}, 32'd0);
    wr(ad(2, 5), 32'h0000_0008);
    wr(ad(2, 4), 32'h0000_0008);
    @(negedge clk); line_in[67] = 1'b1;
    cyc(5);
    chk("R9 irq from bank 2", {31'd0, irq_out}, 32'd1);
    chk("R10 wake from bank 2", {31'd0, wake_out}, 32'd1);

    // R12: bank field 3 does not exist
    wr(ad(3, 5), 32'hFFFF_FFFF);
    rd(ad(3, 5), v); chk("R12 read of missing bank", v, 32'h0);
    rd(ad(1, 5), v); chk("R12 bank 1 untouched", v, 32'h0);
    rd(ad(0, 5), v); chk("R12 bank 0 untouched", v, 32'h0000_0004);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule